// File: doc/BRIEF.md
# Lockable Watchdog Timer with Pre-Timeout Interrupt

This block guards a system against hung software. A down-counter advances once per pulse of a slow tick-enable input. Software must service the counter before it runs out. Servicing takes two key words written in order to a service register. If the count runs out, the block pulses a timeout reset request. A programmable number of ticks before that point, it can raise a pre-timeout interrupt, which gives software a last chance to react.

Software drives the block through a small 16-bit register file with one write strobe and one read strobe. Several fields lock in place after their first write until the next system reset: the enable bit, the interrupt controls and the power-down bit. Software can also request a system reset, and it can force a sticky external alarm output that only power-on reset clears. A reset-status register names the cause of the most recent reset. That register survives system resets.

Top module: `wdg_lock_timer`

Register map, by address: 0 control (CTRL), 1 service (SVC), 2 interrupt control (ICTL), 3 reset cause (RSTAT, read-only), 4 power-down control (PWR).

CTRL field positions:

| Bits | Field |
|------|-------|
| [0] | enable |
| [1] | wait-run |
| [2] | stop-run |
| [3] | debug-run |
| [4] | software-reset, active low |
| [5] | external-alarm, active low |
| [15:8] | timeout value |

ICTL field positions:

| Bits | Field |
|------|-------|
| [15] | interrupt enable |
| [14] | interrupt status, write 1 to clear |
| [7:0] | interrupt count |

RSTAT bits: [0] power-on, [1] software, [2] timeout.

PWR bits: [0] power-down enable.

## Requirements
- R1: After power-on reset, reads return the following, and irq, tout_rst, sw_rst_req and ext_alarm are 0 while pwrdn_en is 1.
  - CTRL = 0xFF32: timeout 0xFF, wait-run 1, the two active-low request bits 1, enable 0.
  - ICTL = 0x0004: interrupt count 4, interrupt disabled.
  - RSTAT = 0x0001.
  - PWR = 0x0001.
- R2: Writing 1 to CTRL[0] sets the enable. Writing 0 clears it only while dbg_in is high; otherwise the enable stays set. A write that takes the enable from 0 to 1 loads the counter with the timeout field of that same write.
- R3: After the counter is loaded with T, tout_rst pulses for one cycle on the (T+1)-th counting tick. It does not pulse again until the next load, and RSTAT becomes 0x0004.
- R4: A tick counts only while enabled. It also does not count while wait_in, stop_in or dbg_in is high and the matching run bit (CTRL[1], [2] or [3]) is 0. With the run bit set to 1, the tick counts in that mode.
- R5: Writing a new timeout value leaves a running count unchanged. The new value is used at the next load.
- R6: Writing 0x5555 and then 0xAAAA to SVC reloads the counter with the timeout field. A lone 0xAAAA does nothing. Any other SVC value written between the two keys cancels the sequence.
- R7: With the interrupt enabled and count C ≤ T, ICTL[14] sets on counting tick T−C+1, that is, C ticks before the timeout tick. irq equals ICTL[14] AND ICTL[15]. Writing 1 to ICTL[14] clears it.
- R8: The first write to ICTL sets the enable and the count. Later writes cannot change either until a system reset.
- R9: Writing 0 to CTRL[4] gives a one-cycle sw_rst_req pulse and sets RSTAT to 0x0002. CTRL[4] always reads 1.
- R10: Writing 0 to CTRL[5] sets ext_alarm, and CTRL[5] then reads 0. A system reset leaves ext_alarm set; only power-on reset clears it.
- R11: Writing 0 to PWR[0] clears pwrdn_en. Writing 1 afterwards cannot set it again until a system reset.
- R12: RSTAT always has exactly one bit set. A system reset leaves RSTAT unchanged; power-on reset makes it 0x0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, keeps RSTAT and ext_alarm |
| tick_en | input | 1 | Slow count enable, one pulse per tick |
| wait_in | input | 1 | Wait low-power mode active |
| stop_in | input | 1 | Stop low-power mode active |
| dbg_in | input | 1 | Debug mode active |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd_en is high, else 0 |
| irq | output | 1 | Pre-timeout interrupt |
| tout_rst | output | 1 | One-cycle timeout reset request |
| sw_rst_req | output | 1 | One-cycle software reset request |
| ext_alarm | output | 1 | Sticky external watchdog alarm |
| pwrdn_en | output | 1 | Power-down enable |

## Verification
The bench builds the block with its default parameters: an 8-bit timeout field, an 8-bit interrupt count and a 3-bit address. These widths keep timeouts short, so expiry, freezing and key sequences are reached in a few dozen ticks. The interrupt count can also equal, exceed or be zero against the timeout value. That covers the interrupt landing on the first tick, sharing the timeout tick, or never firing. Random timeout values and random wait-mode gaps are checked against a tick-count model of expiry and interrupt timing.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // register addresses
   localparam int unsigned A_CTRL  = 0;
   localparam int unsigned A_SVC   = 1;
   localparam int unsigned A_ICTL  = 2;
   localparam int unsigned A_RSTAT = 3;
   localparam int unsigned A_PWR   = 4;

   // control register bit positions
   localparam int unsigned B_EN     = 0;
   localparam int unsigned B_RUN0   = 1;  // wait, stop, debug run bits follow
   localparam int unsigned B_SWRST  = 4;
   localparam int unsigned B_EXT    = 5;
   localparam int unsigned B_TO_LSB = 8;

   // interrupt control bit positions
   localparam int unsigned B_IEN   = 15;
   localparam int unsigned B_ISTAT = 14;

   // reset cause bits
   localparam int unsigned C_POR  = 0;
   localparam int unsigned C_SW   = 1;
   localparam int unsigned C_TOUT = 2;

   localparam int unsigned N_MODES = 3;

   localparam logic [15:0] KEY_ARM  = 16'h5555;
   localparam logic [15:0] KEY_FIRE = 16'hAAAA;
endpackage

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
   import wdg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        svc_wr,
   input  logic [15:0] wdata,
   output logic        fire
);
   logic armed;

   assign fire = svc_wr && armed && (wdata == KEY_FIRE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (svc_wr)
         armed <= (wdata == KEY_ARM);
   end
endmodule

// File: rtl/wdg_downcnt.sv
module wdg_downcnt
   import wdg_pkg::*;
#(
   parameter int unsigned TO_W   = 8,
   parameter int unsigned ICNT_W = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               run_en,
   input  logic [N_MODES-1:0] mode_act,
   input  logic [N_MODES-1:0] mode_run,
   input  logic               load,
   input  logic [TO_W-1:0]    load_val,
   input  logic [ICNT_W-1:0]  icnt,
   output logic               pre_hit,
   output logic               expire
);
   localparam int unsigned CMP_W = (TO_W > ICNT_W) ? TO_W : ICNT_W;

   logic [TO_W-1:0]    cnt;
   logic               spent;
   logic [N_MODES-1:0] hold;
   logic               active;

   for (genvar i = 0; i < N_MODES; i++) begin : g_hold
      assign hold[i] = mode_act[i] & ~mode_run[i];
   end

   assign active  = tick && run_en && !(|hold) && !spent;
   assign expire  = active && (cnt == '0);
   assign pre_hit = active && (CMP_W'(cnt) == CMP_W'(icnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '1;
         spent <= 1'b0;
      end else if (load) begin
         cnt   <= load_val;
         spent <= 1'b0;
      end else if (expire) begin
         spent <= 1'b1;
      end else if (active) begin
         cnt   <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int unsigned TO_W     = 8,
   parameter int unsigned ICNT_W   = 8,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned ICNT_RST = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               por_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [15:0]        wdata,
   input  logic               dbg_in,
   input  logic               pre_hit,
   input  logic               expire,
   output logic               run_en,
   output logic [N_MODES-1:0] mode_run,
   output logic               load,
   output logic [TO_W-1:0]    load_val,
   output logic [ICNT_W-1:0]  icnt,
   output logic               irq_en,
   output logic               irq_stat,
   output logic               irq_lock,
   output logic               tout_rst,
   output logic               sw_rst_req,
   output logic               ext_alarm,
   output logic               pwrdn_en,
   output logic [2:0]         rst_cause,
   output logic [15:0]        rdata
);
   logic            wr_ctrl, wr_svc, wr_ictl, wr_pwr;
   logic            svc_fire;
   logic            sw_req_now;
   logic [TO_W-1:0] to_val;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
   assign wr_svc  = wr_en && (addr == ADDR_W'(A_SVC));
   assign wr_ictl = wr_en && (addr == ADDR_W'(A_ICTL));
   assign wr_pwr  = wr_en && (addr == ADDR_W'(A_PWR));

   wdg_keyseq u_key (
      .clk   (clk),
      .rst_n (rst_n),
      .svc_wr(wr_svc),
      .wdata (wdata),
      .fire  (svc_fire)
   );

   assign sw_req_now = wr_ctrl && !wdata[B_SWRST];
   assign load       = svc_fire || (wr_ctrl && wdata[B_EN] && !run_en);
   assign load_val   = svc_fire ? to_val : wdata[B_TO_LSB +: TO_W];

   // control register, cleared by either reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_en   <= 1'b0;
         mode_run <= N_MODES'(1);
         to_val   <= '1;
      end else if (wr_ctrl) begin
         to_val   <= wdata[B_TO_LSB +: TO_W];
         mode_run <= wdata[B_RUN0 +: N_MODES];
         if (wdata[B_EN])
            run_en <= 1'b1;
         else if (dbg_in)
            run_en <= 1'b0;
      end
   end

   // interrupt control with first-write lock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en   <= 1'b0;
         icnt     <= ICNT_W'(ICNT_RST);
         irq_lock <= 1'b0;
         irq_stat <= 1'b0;
      end else begin
         if (wr_ictl && !irq_lock) begin
            irq_en   <= wdata[B_IEN];
            icnt     <= wdata[ICNT_W-1:0];
            irq_lock <= 1'b1;
         end
         if (pre_hit && irq_en)
            irq_stat <= 1'b1;
         else if (wr_ictl && wdata[B_ISTAT])
            irq_stat <= 1'b0;
      end
   end

   // request pulses and power-down bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tout_rst   <= 1'b0;
         sw_rst_req <= 1'b0;
         pwrdn_en   <= 1'b1;
      end else begin
         tout_rst   <= expire;
         sw_rst_req <= sw_req_now;
         if (wr_pwr)
            pwrdn_en <= pwrdn_en & wdata[0];
      end
   end

   // state that only power-on reset clears
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rst_cause <= 3'b001;
         ext_alarm <= 1'b0;
      end else begin
         if (sw_req_now)
            rst_cause <= 3'b001 << C_SW;
         else if (expire)
            rst_cause <= 3'b001 << C_TOUT;
         if (wr_ctrl && !wdata[B_EXT])
            ext_alarm <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(A_CTRL): begin
            rdata[B_EN]                  = run_en;
            rdata[B_RUN0 +: N_MODES]     = mode_run;
            rdata[B_SWRST]               = 1'b1;
            rdata[B_EXT]                 = ~ext_alarm;
            rdata[B_TO_LSB +: TO_W]      = to_val;
         end
         ADDR_W'(A_ICTL): begin
            rdata[B_IEN]        = irq_en;
            rdata[B_ISTAT]      = irq_stat;
            rdata[ICNT_W-1:0]   = icnt;
         end
         ADDR_W'(A_RSTAT): rdata[2:0] = rst_cause;
         ADDR_W'(A_PWR):   rdata[0]   = pwrdn_en;
         default:          rdata      = '0;
      endcase
   end
endmodule

// File: rtl/wdg_lock_timer.sv
module wdg_lock_timer
   import wdg_pkg::*;
#(
   parameter int unsigned TO_W     = 8,
   parameter int unsigned ICNT_W   = 8,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned ICNT_RST = 4
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              tick_en,
   input  logic              wait_in,
   input  logic              stop_in,
   input  logic              dbg_in,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   output logic [15:0]       rdata,
   output logic              irq,
   output logic              tout_rst,
   output logic              sw_rst_req,
   output logic              ext_alarm,
   output logic              pwrdn_en
);
   if (TO_W < 1 || TO_W > 8) begin : g_bad_to_w
      $error("TO_W must lie in 1..8 to fit the control register");
   end
   if (ICNT_W < 1 || ICNT_W > 14) begin : g_bad_icnt_w
      $error("ICNT_W must lie in 1..14 to fit below the status bit");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("ADDR_W must be at least 3");
   end

   logic               rst_all_n;
   logic               run_en;
   logic [N_MODES-1:0] mode_run;
   logic [N_MODES-1:0] mode_act;
   logic               load;
   logic [TO_W-1:0]    load_val;
   logic [ICNT_W-1:0]  icnt;
   logic               irq_en, irq_stat, irq_lock;
   logic               pre_hit, expire;
   logic [2:0]         rst_cause;
   logic [15:0]        reg_rdata;

   assign rst_all_n = por_n & sys_rst_n;
   assign mode_act  = {dbg_in, stop_in, wait_in};

   wdg_regs #(
      .TO_W(TO_W), .ICNT_W(ICNT_W), .ADDR_W(ADDR_W), .ICNT_RST(ICNT_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_all_n),
      .por_n     (por_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .dbg_in    (dbg_in),
      .pre_hit   (pre_hit),
      .expire    (expire),
      .run_en    (run_en),
      .mode_run  (mode_run),
      .load      (load),
      .load_val  (load_val),
      .icnt      (icnt),
      .irq_en    (irq_en),
      .irq_stat  (irq_stat),
      .irq_lock  (irq_lock),
      .tout_rst  (tout_rst),
      .sw_rst_req(sw_rst_req),
      .ext_alarm (ext_alarm),
      .pwrdn_en  (pwrdn_en),
      .rst_cause (rst_cause),
      .rdata     (reg_rdata)
   );

   wdg_downcnt #(
      .TO_W(TO_W), .ICNT_W(ICNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_all_n),
      .tick    (tick_en),
      .run_en  (run_en),
      .mode_act(mode_act),
      .mode_run(mode_run),
      .load    (load),
      .load_val(load_val),
      .icnt    (icnt),
      .pre_hit (pre_hit),
      .expire  (expire)
   );

   assign irq   = irq_stat & irq_en;
   assign rdata = rd_en ? reg_rdata : '0;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
   import wdg_pkg::*;
#(
   parameter int unsigned ICNT_W = 8
)(
   input logic              clk,
   input logic              por_n,
   input logic              rst_all_n,
   input logic              dbg_in,
   input logic              run_en,
   input logic              irq_lock,
   input logic              irq_en,
   input logic [ICNT_W-1:0] icnt,
   input logic              pwrdn_en,
   input logic              ext_alarm,
   input logic              sw_rst_req,
   input logic              tout_rst,
   input logic [2:0]        rst_cause
);
   a_r2_enable_holds: assert property (@(posedge clk) disable iff (!rst_all_n)
      (run_en && !dbg_in) |=> run_en);

   a_r3_tout_cause: assert property (@(posedge clk) disable iff (!rst_all_n)
      (tout_rst && !sw_rst_req) |-> rst_cause[C_TOUT]);

   a_r8_ictl_locked: assert property (@(posedge clk) disable iff (!rst_all_n)
      irq_lock |=> ($stable(icnt) && $stable(irq_en)));

   a_r9_sw_cause: assert property (@(posedge clk) disable iff (!rst_all_n)
      sw_rst_req |-> rst_cause[C_SW]);

   a_r10_ext_sticky: assert property (@(posedge clk) disable iff (!por_n)
      ext_alarm |=> ext_alarm);

   a_r11_pwrdn_fixed: assert property (@(posedge clk) disable iff (!rst_all_n)
      !pwrdn_en |=> !pwrdn_en);

   a_r12_one_cause: assert property (@(posedge clk) disable iff (!por_n)
      $countones(rst_cause) == 1);
endmodule

bind wdg_lock_timer wdg_checker #(.ICNT_W(ICNT_W)) chk_i (
   .clk       (clk),
   .por_n     (por_n),
   .rst_all_n (rst_all_n),
   .dbg_in    (dbg_in),
   .run_en    (run_en),
   .irq_lock  (irq_lock),
   .irq_en    (irq_en),
   .icnt      (icnt),
   .pwrdn_en  (pwrdn_en),
   .ext_alarm (ext_alarm),
   .sw_rst_req(sw_rst_req),
   .tout_rst  (tout_rst),
   .rst_cause (rst_cause)
);

// File: tb/wdg_lock_timer_tb_top.sv
`timescale 1ns/1ps
module wdg_lock_timer_tb_top;
   localparam int ADDR_W = 3;

   logic              clk = 1'b0;
   logic              por_n = 1'b0, sys_rst_n = 1'b0;
   logic              tick_en = 1'b0, wait_in = 1'b0, stop_in = 1'b0, dbg_in = 1'b0;
   logic              wr_en = 1'b0, rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [15:0]       wdata = '0;
   logic [15:0]       rdata;
   logic              irq, tout_rst, sw_rst_req, ext_alarm, pwrdn_en;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic sw_seen;

   always #2.5 clk = ~clk;

   wdg_lock_timer dut_i (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick_en(tick_en),
      .wait_in(wait_in), .stop_in(stop_in), .dbg_in(dbg_in),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .irq(irq), .tout_rst(tout_rst), .sw_rst_req(sw_rst_req),
      .ext_alarm(ext_alarm), .pwrdn_en(pwrdn_en)
   );

   function automatic int model_tout(int t);
      return t + 1;
   endfunction

   function automatic int model_irq(int t, int c);
      return (c <= t) ? (t - c + 1) : 0;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
      @(negedge clk); wr_en = 1'b0; sw_seen = sw_rst_req;
   endtask

   task automatic ck_rd(int a, logic [15:0] exp, string req);
      logic [15:0] d;
      @(negedge clk); rd_en = 1'b1; addr = ADDR_W'(a);
      #1 d = rdata; rd_en = 1'b0;
      chk(req, 32'(d), 32'(exp));
   endtask

   task automatic tick1(logic wi, output logic to, output logic iq);
      @(negedge clk); tick_en = 1'b1; wait_in = wi;
      @(negedge clk); tick_en = 1'b0; wait_in = 1'b0; to = tout_rst; iq = irq;
   endtask

   task automatic ticks(int n, logic wi, output int tos);
      logic to, iq;
      tos = 0;
      for (int i = 0; i < n; i++) begin
         tick1(wi, to, iq);
         if (to) tos++;
      end
   endtask

   // k-th tick must expire, none before
   task automatic expect_expire(int k, logic wi, string req);
      int tos;
      ticks(k - 1, wi, tos);
      chk({req, " early"}, 32'(tos), 0);
      ticks(1, wi, tos);
      chk({req, " expiry"}, 32'(tos), 1);
   endtask

   task automatic service();
      wr(1, 16'h5555);
      wr(1, 16'hAAAA);
   endtask

   task automatic do_por();
      por_n = 1'b0; sys_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1; sys_rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_sys();
      @(negedge clk); sys_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      sys_rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #900_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int tos;
      logic to, iq;
      void'($urandom(32'd4242));
      do_por();

      // R1 defaults
      ck_rd(0, 16'hFF32, "R1 ctrl");
      ck_rd(2, 16'h0004, "R1 ictl");
      ck_rd(3, 16'h0001, "R1 rstat");
      ck_rd(4, 16'h0001, "R1 pwr");
      chk("R1 outputs", {28'b0, irq, tout_rst, sw_rst_req, ext_alarm}, 0);
      chk("R1 pwrdn", 32'(pwrdn_en), 1);

      // R4 disabled counter never expires
      ticks(300, 1'b0, tos);
      chk("R4 disabled", 32'(tos), 0);

      // R2/R3 enable loads T=5
      wr(0, 16'h0531);
      expect_expire(6, 1'b0, "R3");
      ck_rd(3, 16'h0004, "R3 cause");
      ticks(20, 1'b0, tos);
      chk("R3 single pulse", 32'(tos), 0);

      // R2 enable cannot be cleared without debug
      wr(0, 16'h0530);
      ck_rd(0, 16'h0531, "R2 no clear");

      // R4 wait freeze with run bit 0
      service();
      ticks(20, 1'b1, tos);
      chk("R4 wait freeze", 32'(tos), 0);
      expect_expire(6, 1'b0, "R4 after wait");
      wr(0, 16'h0533);
      service();
      expect_expire(6, 1'b1, "R4 wait run");
      service();
      stop_in = 1'b1;
      ticks(20, 1'b0, tos);
      stop_in = 1'b0;
      chk("R4 stop freeze", 32'(tos), 0);
      expect_expire(6, 1'b0, "R4 after stop");

      // R6 key sequence
      service();
      ticks(3, 1'b0, tos);
      wr(1, 16'hAAAA);
      expect_expire(3, 1'b0, "R6 lone key");
      service();
      ticks(3, 1'b0, tos);
      wr(1, 16'h5555); wr(1, 16'h1234); wr(1, 16'hAAAA);
      expect_expire(3, 1'b0, "R6 broken pair");
      service();
      ticks(3, 1'b0, tos);
      service();
      expect_expire(6, 1'b0, "R6 pair reload");

      // R5 timeout rewrite takes effect at next load
      service();
      wr(0, 16'h0933);
      expect_expire(6, 1'b0, "R5 old value");
      service();
      expect_expire(10, 1'b0, "R5 new value");

      // R7/R8 pre-timeout interrupt
      wr(2, 16'h8003);
      service();
      ticks(6, 1'b0, tos);
      chk("R7 irq early", 32'(irq), 0);
      tick1(1'b0, to, iq);
      chk("R7 irq fires", 32'(iq), 1);
      ck_rd(2, 16'hC003, "R7 status");
      wr(2, 16'h4000);
      chk("R7 irq clear", 32'(irq), 0);
      ck_rd(2, 16'h8003, "R8 lock after clear");
      wr(2, 16'h0007);
      ck_rd(2, 16'h8003, "R8 lock holds");

      // R4 debug freeze, R2 debug clear and re-enable
      service();
      dbg_in = 1'b1;
      ticks(30, 1'b0, tos);
      chk("R4 debug freeze", 32'(tos), 0);
      wr(0, 16'h0932);
      ck_rd(0, 16'h0932, "R2 debug clear");
      dbg_in = 1'b0;
      wr(0, 16'h0433);
      expect_expire(5, 1'b0, "R2 re-enable load");

      // R9 software reset request
      wr(0, 16'h0423);
      chk("R9 pulse", 32'(sw_seen), 1);
      @(negedge clk);
      chk("R9 pulse ends", 32'(sw_rst_req), 0);
      ck_rd(0, 16'h0433, "R9 bit reads one");
      ck_rd(3, 16'h0002, "R9 cause");
      do_sys();
      ck_rd(3, 16'h0002, "R12 kept");
      ck_rd(0, 16'hFF32, "R1 after system reset");
      wr(2, 16'h8005);
      ck_rd(2, 16'h8005, "R8 unlocked by reset");

      // R10 external alarm
      wr(0, 16'hFF12);
      chk("R10 set", 32'(ext_alarm), 1);
      do_sys();
      chk("R10 survives", 32'(ext_alarm), 1);
      ck_rd(0, 16'hFF12, "R10 readback");
      do_por();
      chk("R10 por clears", 32'(ext_alarm), 0);
      ck_rd(3, 16'h0001, "R12 por");

      // R11 power-down bit
      wr(4, 16'h0000);
      chk("R11 cleared", 32'(pwrdn_en), 0);
      wr(4, 16'h0001);
      ck_rd(4, 16'h0000, "R11 fixed");
      do_sys();
      chk("R11 reset", 32'(pwrdn_en), 1);

      // random timeouts with wait gaps against the tick model
      begin
         int ic;
         ic = int'($urandom_range(0, 12));
         wr(2, 16'h8000 | 16'(ic));
         for (int it = 0; it < 16; it++) begin
            int t, eff, irq_at, tout_at;
            t = int'($urandom_range(1, 30));
            wr(0, (16'(t) << 8) | 16'h0031);
            service();
            wr(2, 16'h4000);
            eff = 0; irq_at = 0; tout_at = 0;
            for (int s = 0; s < 300 && tout_at == 0; s++) begin
               logic wi;
               wi = ($urandom % 4) == 0;
               tick1(wi, to, iq);
               if (!wi) eff++;
               if (iq && irq_at == 0) irq_at = eff;
               if (to) tout_at = eff;
            end
            chk("R3 random expiry", 32'(tout_at), 32'(model_tout(t)));
            chk("R7 random irq", 32'(irq_at), 32'(model_irq(t, ic)));
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule